// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small accumulator processor. Each cycle it may fold in one of several kinds of update: the flags produced by an arithmetic, shift/rotate or data-transfer result; a bit-test of a memory operand; an explicit set or clear of a single flag; an interrupt or software-break entry; or a byte restored from the stack. The live flags drive branch decisions and the interrupt-accept mask. A combinational push image gives the byte to write to the stack on interrupt entry.

The break marker is never held in the register. It exists only in the push image and only during a software-break entry. The overflow flag can be cleared by command but never set by one. It becomes 1 only through arithmetic, a bit-test or a stack restore. In decimal mode the block still loads Z, V and N from the result it is given; the values arriving from the ALU in that mode carry no guarantee.

Top module: `psr_flags`

## Requirements
- R1: The bit layout, from bit 0 to bit 7, is C, Z, I, D, B, T, V, N. While `rst_n` is low and directly after reset, `flags` reads 8'h04: I is 1 and all other bits are 0.
- R2: Command bit 0 (arithmetic) loads C from `alu_carry`, V from `alu_ovf`, Z with (`alu_res`==0) and N with `alu_res[7]`, visible after the next clock edge. D, I and T are left unchanged.
- R3: Command bit 1 (shift/rotate) loads C from `alu_carry`, Z with (`alu_res`==0) and N with `alu_res[7]`. V, D, I and T are left unchanged.
- R4: Command bit 2 (data transfer) loads Z with (`alu_res`==0) and N with `alu_res[7]`. C and V are left unchanged.
- R5: Command bit 3 (bit test) loads N from `mem_opd[7]`, V from `mem_opd[6]` and Z with (`alu_res`==0). C is left unchanged.
- R6: Command bits 4 to 12 act on a single flag each: set C, clear C, set I, clear I, set D, clear D, set T, clear T, clear V. Every other flag is left unchanged.
- R7: No command sets V. After any set command, V is no higher than it was before.
- R8: Bit 4 of `flags` is always 0. `push_img` equals `flags`, except that its bit 4 equals `brk_enter`.
- R9: `irq_enter` or `brk_enter` sets I to 1 at the next edge. `irq_mask` always equals I.
- R10: When `pull_en` is high, every flag except B is loaded from `pull_data` at the next edge. This load takes precedence over any command given in the same cycle.
- R11: When a stack restore and an interrupt or break entry occur in the same cycle, I becomes 1. All other flags come from `pull_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 13 | One-hot update command (bit map in R2 to R6) |
| alu_res | input | 8 | ALU or transfer result byte |
| alu_carry | input | 1 | ALU carry or borrow out |
| alu_ovf | input | 1 | ALU signed overflow |
| mem_opd | input | 8 | Memory operand used by bit test |
| irq_enter | input | 1 | Hardware interrupt entry strobe |
| brk_enter | input | 1 | Software break entry strobe |
| pull_en | input | 1 | Stack restore strobe |
| pull_data | input | 8 | Byte restored from the stack |
| flags | output | 8 | Live status flags |
| push_img | output | 8 | Status byte to push on entry |
| irq_mask | output | 1 | Interrupt-accept mask (I flag) |

## Verification
Two functions can land in the same cycle: a stack restore and an interrupt or break entry. Both write I, and they must resolve so that I ends at 1 while the other flags come from the pulled byte. The bench provokes this with directed steps and with a random phase that raises the strobes together. It also combines a restore with a command in the same cycle. Each outcome is judged against a behavioural reference model that is compared every clock.

// File: rtl/psr_flags.sv
module psr_flags #(
  parameter int NCMD = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMD-1:0] cmd,
  input  logic [7:0]      alu_res,
  input  logic            alu_carry,
  input  logic            alu_ovf,
  input  logic [7:0]      mem_opd,
  input  logic            irq_enter,
  input  logic            brk_enter,
  input  logic            pull_en,
  input  logic [7:0]      pull_data,
  output logic [7:0]      flags,
  output logic [7:0]      push_img,
  output logic            irq_mask
);
  localparam int P_C = 0, P_Z = 1, P_I = 2, P_D = 3, P_B = 4, P_T = 5, P_V = 6, P_N = 7;
  localparam int OP_ARITH = 0, OP_SHIFT = 1, OP_XFER = 2, OP_BIT = 3;
  localparam int OP_SETC = 4, OP_CLRC = 5, OP_SETI = 6, OP_CLRI = 7;
  localparam int OP_SETD = 8, OP_CLRD = 9, OP_SETT = 10, OP_CLRT = 11, OP_CLRV = 12;

  logic c_q, z_q, i_q, d_q, t_q, v_q, n_q;
  logic c_n, z_n, i_n, d_n, t_n, v_n, n_n;

  wire res_zero = (alu_res == 8'h00);
  wire res_neg  = alu_res[7];
  wire entry    = irq_enter | brk_enter;
  wire res_load = cmd[OP_ARITH] | cmd[OP_SHIFT] | cmd[OP_XFER];

  always_comb begin
    c_n = c_q; z_n = z_q; i_n = i_q; d_n = d_q;
    t_n = t_q; v_n = v_q; n_n = n_q;
    if (cmd[OP_ARITH] | cmd[OP_SHIFT]) c_n = alu_carry;
    if (res_load | cmd[OP_BIT])        z_n = res_zero;
    if (res_load)                      n_n = res_neg;
    if (cmd[OP_BIT])                   n_n = mem_opd[7];
    if (cmd[OP_ARITH])                 v_n = alu_ovf;
    if (cmd[OP_BIT])                   v_n = mem_opd[6];
    if (cmd[OP_SETC]) c_n = 1'b1;
    if (cmd[OP_CLRC]) c_n = 1'b0;
    if (cmd[OP_SETI]) i_n = 1'b1;
    if (cmd[OP_CLRI]) i_n = 1'b0;
    if (cmd[OP_SETD]) d_n = 1'b1;
    if (cmd[OP_CLRD]) d_n = 1'b0;
    if (cmd[OP_SETT]) t_n = 1'b1;
    if (cmd[OP_CLRT]) t_n = 1'b0;
    if (cmd[OP_CLRV]) v_n = 1'b0;
    if (pull_en) begin
      c_n = pull_data[P_C]; z_n = pull_data[P_Z]; i_n = pull_data[P_I];
      d_n = pull_data[P_D]; t_n = pull_data[P_T]; v_n = pull_data[P_V];
      n_n = pull_data[P_N];
    end
    if (entry) i_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0; z_q <= 1'b0; i_q <= 1'b1; d_q <= 1'b0;
      t_q <= 1'b0; v_q <= 1'b0; n_q <= 1'b0;
    end else begin
      c_q <= c_n; z_q <= z_n; i_q <= i_n; d_q <= d_n;
      t_q <= t_n; v_q <= v_n; n_q <= n_n;
    end
  end

  assign flags    = {n_q, v_q, t_q, 1'b0,      d_q, i_q, z_q, c_q};
  assign push_img = {n_q, v_q, t_q, brk_enter, d_q, i_q, z_q, c_q};
  assign irq_mask = i_q;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd)); // R6
  AST_ARITH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[OP_ARITH] && !pull_en) |=> (flags[P_Z] == ($past(alu_res) == 8'h00))); // R2
  AST_SHIFT_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[OP_SHIFT] && !pull_en) |=> $stable(flags[P_V])); // R3
  AST_BIT_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[OP_BIT] && !pull_en) |=> (flags[P_N:P_V] == $past(mem_opd[7:6]))); // R5
  AST_NO_SET_V: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd[OP_ARITH] && !cmd[OP_BIT] && !pull_en) |=> (flags[P_V] <= $past(flags[P_V]))); // R7
  AST_PUSH_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    push_img[P_B] == brk_enter); // R8
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter || brk_enter) |=> irq_mask); // R9
  AST_PULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en && !irq_enter && !brk_enter) |=> (flags == ($past(pull_data) & 8'hEF))); // R10
  AST_PULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en && (irq_enter || brk_enter)) |=> (flags == (($past(pull_data) & 8'hEF) | 8'h04))); // R11
endmodule

// File: tb/psr_flags_bench.sv
`timescale 1ns/1ps
module psr_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] cmd = '0;
  logic [7:0] alu_res = '0, mem_opd = '0, pull_data = '0;
  logic alu_carry = 1'b0, alu_ovf = 1'b0, irq_enter = 1'b0, brk_enter = 1'b0, pull_en = 1'b0;
  logic [7:0] flags, push_img;
  logic irq_mask;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_fl = 8'h04;
  string prev_tag = "R1";

  always #10 clk = ~clk;

  psr_flags u_psr_flags (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .alu_res(alu_res), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .mem_opd(mem_opd), .irq_enter(irq_enter), .brk_enter(brk_enter),
    .pull_en(pull_en), .pull_data(pull_data), .flags(flags), .push_img(push_img),
    .irq_mask(irq_mask)
  );

  task automatic cmp8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // reference model: one whole cycle of behaviour, written from the requirements
  function automatic logic [7:0] model(input logic [7:0] f, input int op, input logic [7:0] r,
                                       input logic cy, input logic ov, input logic [7:0] m,
                                       input logic ent, input logic pl, input logic [7:0] pd);
    logic [7:0] g;
    g = f;
    case (op)
      0: begin g[0] = cy; g[6] = ov; g[1] = (r == 0); g[7] = r[7]; end
      1: begin g[0] = cy; g[1] = (r == 0); g[7] = r[7]; end
      2: begin g[1] = (r == 0); g[7] = r[7]; end
      3: begin g[7] = m[7]; g[6] = m[6]; g[1] = (r == 0); end
      4: g[0] = 1; 5: g[0] = 0;
      6: g[2] = 1; 7: g[2] = 0;
      8: g[3] = 1; 9: g[3] = 0;
      10: g[5] = 1; 11: g[5] = 0;
      12: g[6] = 0;
      default: ;
    endcase
    if (pl) g = pd;
    g[4] = 0;
    if (ent) g[2] = 1;
    return g;
  endfunction

  task automatic step(input string tag, input int op, input logic [7:0] r, input logic cy,
                      input logic ov, input logic [7:0] m, input logic irq, input logic brk,
                      input logic pl, input logic [7:0] pd);
    logic [7:0] pimg;
    @(negedge clk);
    cmd = (op >= 0 && op < 13) ? (13'd1 << op) : 13'd0;
    alu_res = r; alu_carry = cy; alu_ovf = ov; mem_opd = m;
    irq_enter = irq; brk_enter = brk; pull_en = pl; pull_data = pd;
    #8;
    cmp8(prev_tag, "flags", flags, exp_fl);
    cmp8(prev_tag, "irq_mask(R9)", {7'd0, irq_mask}, {7'd0, exp_fl[2]});
    pimg = exp_fl; pimg[4] = brk;
    cmp8("R8", "push_img", push_img, pimg);
    @(posedge clk);
    exp_fl = model(exp_fl, op, r, cy, ov, m, irq | brk, pl, pd);
    prev_tag = tag;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) begin
      @(negedge clk); #8;
      cmp8("R1", "flags in reset", flags, 8'h04);
    end
    @(negedge clk); rst_n = 1'b1;
    step("R2", 0, 8'h00, 1, 1, 8'h00, 0, 0, 0, 8'h00);
    step("R2", 0, 8'h80, 0, 0, 8'h00, 0, 0, 0, 8'h00);
    step("R3", 1, 8'h00, 1, 1, 8'h00, 0, 0, 0, 8'h00);
    step("R3", 1, 8'hC1, 0, 0, 8'h00, 0, 0, 0, 8'h00);
    step("R4", 2, 8'hFF, 0, 1, 8'h00, 0, 0, 0, 8'h00);
    step("R4", 2, 8'h00, 1, 0, 8'h00, 0, 0, 0, 8'h00);
    step("R5", 3, 8'h00, 1, 0, 8'hC0, 0, 0, 0, 8'h00);
    step("R5", 3, 8'h05, 0, 1, 8'h40, 0, 0, 0, 8'h00);
    step("R5", 3, 8'h05, 0, 0, 8'h80, 0, 0, 0, 8'h00);
    for (int op = 4; op < 13; op++)
      step("R6", op, 8'h00, 0, 0, 8'h00, 0, 0, 0, 8'h00);
    step("R6", 0, 8'h01, 1, 1, 8'h00, 0, 0, 0, 8'h00);
    step("R6", 12, 8'h00, 0, 0, 8'h00, 0, 0, 0, 8'h00);
    for (int op = 4; op < 12; op += 2)
      step("R7", op, 8'hFF, 1, 1, 8'hFF, 0, 0, 0, 8'h00);
    step("R7", 7, 8'h00, 0, 0, 8'h00, 0, 0, 0, 8'h00);
    step("R9", -1, 8'h00, 0, 0, 8'h00, 1, 0, 0, 8'h00);
    step("R9", 7, 8'h00, 0, 0, 8'h00, 0, 0, 0, 8'h00);
    step("R9", -1, 8'h00, 0, 0, 8'h00, 0, 1, 0, 8'h00);
    step("R10", -1, 8'h00, 0, 0, 8'h00, 0, 0, 1, 8'hFF);
    step("R10", 6, 8'h00, 0, 0, 8'h00, 0, 0, 1, 8'h00);
    step("R10", 4, 8'h00, 0, 0, 8'h00, 0, 0, 1, 8'h5A);
    step("R11", -1, 8'h00, 0, 0, 8'h00, 1, 0, 1, 8'h00);
    step("R11", 7, 8'h00, 0, 0, 8'h00, 0, 1, 1, 8'hF3);
    for (int k = 0; k < 600; k++) begin
      int op;
      logic [7:0] r, m, pd;
      logic irq, brk, pl;
      op = int'($urandom_range(0, 14)) - 1;
      r = 8'($urandom); m = 8'($urandom); pd = 8'($urandom);
      irq = ($urandom_range(0, 7) == 0);
      brk = !irq && ($urandom_range(0, 7) == 0);
      pl  = ($urandom_range(0, 5) == 0);
      step((pl && (irq || brk)) ? "R11" : "mix", op, r, 1'($urandom), 1'($urandom), m, irq, brk, pl, pd);
    end
    step("R2", -1, 8'h00, 0, 0, 8'h00, 0, 0, 0, 8'h00);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule